// File: doc/BRIEF.md
# HMAC Inner-Hash Message Padder

This unit sits between a message source and a SHA-256 compression engine. It builds the padded message blocks for the inner hash of an HMAC computation. Message bytes arrive as 32-bit words over a valid/ready input. The unit collects them into 64-byte blocks and hands each full block to the engine over a valid/ready output.

When a word is flagged as the last of the message, the unit finishes the padding. It places the 0x80 terminator in the first unused byte lane and clears the remainder of the block to zero. It then writes the message length, in bits, as a 64-bit big-endian value into the last eight bytes. The key-derived block is hashed ahead of the message, so the running byte count starts at 64. The encoded length therefore covers that block as well as the message. If the terminator leaves no room for the length, the unit emits one extra block.

While a block is on offer, input is held off. No block is overwritten until the engine has accepted the one before it.

Top module: `hmac_inner_padder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Byte order:
  - Within an input word, `in_data[31:24]` is the first byte and `in_data[7:0]` the fourth.
  - Block byte offset k appears at `out_block[511-8k -: 8]`.
  - Sixteen non-last words form one block, offered with `out_final` = 0.
- R3: On a word with `in_last` = 1, `in_bytes` (1 to 4) gives the number of valid bytes, taken from the upper lanes first. The byte 0x80 follows the last valid byte directly. Every later byte up to offset 55 is 0, whatever the unused input lanes held.
- R4: Only a block with `out_final` = 1 carries the length. Its offsets 56..63 hold (64 + N) × 8 as a 64-bit big-endian value, where N is the number of message bytes.
- R5: If the tail offset t (N mod 64, nonzero) is at most 55, the padding and length go into a single block, offered with `out_final` = 1.
- R6: If t is 56..63, two blocks are offered:
  - first, a block with `out_final` = 0 that ends in 0x80 and zeros;
  - then a final block that is zero in offsets 0..55 and holds the length in 56..63.
- R7: If N is a nonzero multiple of 64, two blocks are offered:
  - first, the full data block with `out_final` = 0;
  - then a final block with 0x80 at offset 0, zeros through offset 55, and the length.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_block` and `out_final` hold steady. `in_ready` is 0 whenever `out_valid` is 1.
- R9: After the final block of a message is accepted, the byte count restarts at 64 for the next message.
- R10: On a word with `in_last` = 0, `in_bytes` is ignored and all four bytes are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Unit can take a word |
| in_data | input | 32 | Message word, first byte in bits 31:24 |
| in_bytes | input | 3 | Valid bytes in a last word, 1 to 4 |
| in_last | input | 1 | Word is the final one of the message |
| out_valid | output | 1 | Block offered to the hash engine |
| out_ready | input | 1 | Engine accepts the block |
| out_block | output | 512 | Block, offset 0 in bits 511:504 |
| out_final | output | 1 | Block is the last of the message |

## Verification
The bench sends messages whose tails land on every padding case:
- tails of 1, 3, 4 and 5 bytes, and tails just before, at and just after offset 56;
- exact block multiples;
- multi-block messages.

A padder that miscounted the preloaded block would write a length 512 bits short. One that tested room for the length with the wrong bound would either overwrite the terminator with the length or skip the extra block. One that ignored the exact-boundary case would drop the terminator block entirely.

The unused lanes of a partial last word and the byte count on non-last words are filled with junk. A leak of either shows up as wrong data bytes. Backpressure on the output checks that a waiting block never changes and that input stays held off.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int BLK_BYTES  = 64;
  localparam int WORD_BYTES = 4;
  localparam int WORDS      = BLK_BYTES / WORD_BYTES;
  localparam int WPTR_W     = $clog2(WORDS);
  localparam int OFF_W      = WPTR_W + 3;
  localparam int LEN_BYTES  = 8;
  localparam int LEN_OFF    = BLK_BYTES - LEN_BYTES;
  localparam int BLK_W      = BLK_BYTES * 8;

  typedef enum logic [1:0] {
    FOL_NONE     = 2'd0,
    FOL_LEN      = 2'd1,
    FOL_MARK_LEN = 2'd2
  } follow_e;

  // Total bit count for the length field.
  function automatic logic [63:0] bits_of(input logic [63:0] nbytes);
    return nbytes << 3;
  endfunction

  // Length still fits after the terminator placed at offset t.
  function automatic logic tail_fits(input logic [OFF_W-1:0] t);
    return t < OFF_W'(LEN_OFF);
  endfunction

  // Offset of the first byte after the data of the current word.
  function automatic logic [OFF_W-1:0] tail_offset(input logic [WPTR_W-1:0] wptr,
                                                   input logic [2:0] nb);
    return {1'b0, wptr, 2'b00} + OFF_W'(nb);
  endfunction
endpackage

// File: rtl/hip_byte_count.sv
module hip_byte_count #(
  parameter int CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [2:0]       add_val,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(hip_pkg::BLK_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= PRELOAD;
    else if (restart) count <= PRELOAD;
    else if (add_en)  count <= count + CNT_W'(add_val);
  end
endmodule

// File: rtl/hip_ctrl.sv
module hip_ctrl
  import hip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [2:0]        nb,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_final,
  output logic              wr_word,
  output logic              wr_tail,
  output logic              wr_follow,
  output follow_e           follow_kind,
  output logic              follow_pend,
  output logic [WPTR_W-1:0] wptr,
  output logic [OFF_W-1:0]  tail_off
);
  typedef enum logic {ST_FILL, ST_EMIT} state_e;

  state_e  st;
  follow_e fol;
  logic    acc, hs;

  assign in_ready    = (st == ST_FILL);
  assign out_valid   = (st == ST_EMIT);
  assign acc         = in_valid && in_ready;
  assign hs          = out_valid && out_ready;
  assign tail_off    = tail_offset(wptr, nb);
  assign wr_word     = acc && !in_last;
  assign wr_tail     = acc && in_last;
  assign wr_follow   = hs && (fol != FOL_NONE);
  assign follow_kind = fol;
  assign follow_pend = (fol != FOL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_FILL;
      fol       <= FOL_NONE;
      wptr      <= '0;
      out_final <= 1'b0;
    end else if (st == ST_FILL) begin
      if (acc && in_last) begin
        st        <= ST_EMIT;
        wptr      <= '0;
        out_final <= tail_fits(tail_off);
        if (tail_off == OFF_W'(BLK_BYTES))  fol <= FOL_MARK_LEN;
        else if (!tail_fits(tail_off))      fol <= FOL_LEN;
        else                                fol <= FOL_NONE;
      end else if (acc) begin
        wptr <= wptr + 1'b1;
        if (wptr == WPTR_W'(WORDS - 1)) begin
          st        <= ST_EMIT;
          out_final <= 1'b0;
          fol       <= FOL_NONE;
        end
      end
    end else if (out_ready) begin
      if (fol != FOL_NONE) begin
        out_final <= 1'b1;
        fol       <= FOL_NONE;
      end else begin
        st <= ST_FILL;
      end
    end
  end
endmodule

// File: rtl/hip_block_buf.sv
module hip_block_buf
  import hip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word,
  input  logic              wr_tail,
  input  logic              wr_follow,
  input  follow_e           follow_kind,
  input  logic [WPTR_W-1:0] wptr,
  input  logic [OFF_W-1:0]  tail_off,
  input  logic [31:0]       word,
  input  logic [63:0]       len_bits,
  output logic [BLK_W-1:0]  blk
);
  logic word_start_le_off [BLK_BYTES];

  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_byte
    localparam int WIDX = k / WORD_BYTES;
    localparam int LANE = k % WORD_BYTES;
    localparam int LB   = (k >= LEN_OFF) ? (BLK_BYTES - 1 - k) : 0;
    localparam logic [OFF_W-1:0] KOFF = OFF_W'(k);

    logic [7:0] cur, nxt, dbyte, lbyte;

    assign cur   = blk[BLK_W-1-8*k -: 8];
    assign dbyte = word[31-8*LANE -: 8];
    assign lbyte = (k >= LEN_OFF) ? len_bits[8*LB +: 8] : 8'h00;
    assign word_start_le_off[k] = ({1'b0, wptr, 2'b00} <= KOFF);

    always_comb begin
      nxt = cur;
      if (wr_word) begin
        if (wptr == WPTR_W'(WIDX)) nxt = dbyte;
      end else if (wr_tail) begin
        if (!word_start_le_off[k])                  nxt = cur;
        else if (KOFF < tail_off)                   nxt = dbyte;
        else if (KOFF == tail_off)                  nxt = 8'h80;
        else if (k >= LEN_OFF && tail_fits(tail_off)) nxt = lbyte;
        else                                        nxt = 8'h00;
      end else if (wr_follow) begin
        if (k >= LEN_OFF)                           nxt = lbyte;
        else if (k == 0 && follow_kind == FOL_MARK_LEN) nxt = 8'h80;
        else                                        nxt = 8'h00;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk[BLK_W-1-8*k -: 8] <= 8'h00;
      else        blk[BLK_W-1-8*k -: 8] <= nxt;
    end
  end
endmodule

// File: rtl/hmac_inner_padder.sv
module hmac_inner_padder
  import hip_pkg::*;
#(
  parameter int CNT_W = 61
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_data,
  input  logic [2:0]   in_bytes,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [511:0] out_block,
  output logic         out_final
);
  logic              wr_word, wr_tail, wr_follow, follow_pend;
  follow_e           follow_kind;
  logic [WPTR_W-1:0] wptr;
  logic [OFF_W-1:0]  tail_off;
  logic [2:0]        nb;
  logic [CNT_W-1:0]  count, total;
  logic [63:0]       len_bits;
  logic              msg_done;

  assign nb       = in_last ? in_bytes : 3'd4;
  assign total    = wr_tail ? (count + CNT_W'(nb)) : count;
  assign len_bits = bits_of(64'(total));
  assign msg_done = out_valid && out_ready && out_final;

  hip_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .nb          (nb),
    .out_ready   (out_ready),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_final   (out_final),
    .wr_word     (wr_word),
    .wr_tail     (wr_tail),
    .wr_follow   (wr_follow),
    .follow_kind (follow_kind),
    .follow_pend (follow_pend),
    .wptr        (wptr),
    .tail_off    (tail_off)
  );

  hip_byte_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (wr_word || wr_tail),
    .add_val (nb),
    .restart (msg_done),
    .count   (count)
  );

  hip_block_buf u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_word     (wr_word),
    .wr_tail     (wr_tail),
    .wr_follow   (wr_follow),
    .follow_kind (follow_kind),
    .wptr        (wptr),
    .tail_off    (tail_off),
    .word        (in_data),
    .len_bits    (len_bits),
    .blk         (out_block)
  );
endmodule

// File: rtl/hip_checker.sv
module hip_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [511:0] out_block,
  input logic         out_final,
  input logic         follow_pend
);
  AST_NO_INPUT_WHILE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8

  AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final))); // R8

  AST_LEN_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_final) |-> (out_block[2:0] == 3'b000 && out_block[63:0] >= 64'd512)); // R4

  AST_FOLLOW_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && follow_pend) |=> (out_valid && out_final)); // R6

  AST_FOLLOW_NOT_YET_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && follow_pend) |-> !out_final); // R7
endmodule

bind hmac_inner_padder hip_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_block   (out_block),
  .out_final   (out_final),
  .follow_pend (follow_pend)
);

// File: tb/hmac_inner_padder_tb.sv
`timescale 1ns/1ps
module hmac_inner_padder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_data = '0;
  logic [2:0]   in_bytes = 3'd0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_block;
  logic         out_final;

  always #4 clk = ~clk;

  hmac_inner_padder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_block(out_block), .out_final(out_final)
  );

  int checks = 0;
  int fails  = 0;
  logic [511:0] exp_blk_q [$];
  bit           exp_fin_q [$];
  string        exp_tag_q [$];

  // Reference padding model built from the textbook rule.
  task automatic queue_expected(input int n);
    byte unsigned q [$];
    logic [63:0] bits;
    string tag;
    int t;
    for (int i = 0; i < n; i++) q.push_back(8'((n * 7 + i * 13 + 1) & 255));
    q.push_back(8'h80);
    while (q.size() % 64 != 56) q.push_back(8'h00);
    bits = 64'(64 + n) * 64'd8;
    for (int i = 7; i >= 0; i--) q.push_back(bits[8*i +: 8]);
    t = n % 64;
    if (t == 0)       tag = "R7";
    else if (t <= 55) tag = "R5";
    else              tag = "R6";
    for (int b = 0; b < q.size() / 64; b++) begin
      logic [511:0] e;
      for (int k = 0; k < 64; k++) e[511-8*k -: 8] = q[b*64 + k];
      exp_blk_q.push_back(e);
      exp_fin_q.push_back(b == q.size() / 64 - 1);
      exp_tag_q.push_back($sformatf("%s R2 R3 R4 R9 R10 len=%0d blk=%0d", tag, n, b));
    end
  endtask

  task automatic put_word(input logic [31:0] d, input logic [2:0] nbytes, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_bytes = nbytes; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_msg(input int n);
    queue_expected(n);
    for (int w = 0; w * 4 < n; w++) begin
      logic [31:0] d;
      int nb;
      logic last;
      nb   = (n - 4 * w >= 4) ? 4 : n - 4 * w;
      last = (4 * w + 4 >= n);
      for (int l = 0; l < 4; l++)
        d[31-8*l -: 8] = (l < nb) ? 8'((n * 7 + (4 * w + l) * 13 + 1) & 255) : 8'hA5;
      // R10: non-last words carry a junk byte count of 1
      put_word(d, last ? 3'(nb) : 3'd1, last);
    end
  endtask

  // Output monitor with backpressure, sampled away from the active edge.
  int  rdy_cnt = 0;
  bit  hold_prev = 0;
  logic [511:0] prev_blk;
  bit           prev_fin;
  always @(negedge clk) begin
    if (rst_n) begin
      bit r;
      if (out_valid) begin
        checks++;
        if (in_ready) begin
          fails++;
          $display("FAIL R8 in_ready=%0d expected 0 while block offered", in_ready);
        end
      end
      if (hold_prev) begin
        checks++;
        if (!out_valid || out_block !== prev_blk || out_final !== prev_fin) begin
          fails++;
          $display("FAIL R8 held block changed: valid=%0d fin=%0d expected valid=1 fin=%0d",
                   out_valid, out_final, prev_fin);
        end
      end
      rdy_cnt++;
      r = (rdy_cnt % 3 != 0);
      out_ready = r;
      if (out_valid && r) begin
        checks++;
        if (exp_blk_q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected block actual=%h expected none", out_block);
        end else begin
          logic [511:0] e;
          bit f;
          string tg;
          e = exp_blk_q.pop_front(); f = exp_fin_q.pop_front(); tg = exp_tag_q.pop_front();
          if (out_block !== e || out_final !== f) begin
            fails++;
            $display("FAIL %s actual=%h fin=%0d expected=%h fin=%0d", tg, out_block, out_final, e, f);
          end
        end
      end
      hold_prev = out_valid && !r;
      prev_blk  = out_block;
      prev_fin  = out_final;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lens [15] = '{1, 3, 4, 5, 55, 56, 57, 60, 63, 64, 65, 119, 120, 128, 200};
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: out_valid=%0d in_ready=%0d expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 after release: out_valid=%0d in_ready=%0d expected 0 1", out_valid, in_ready);
    end
    foreach (lens[i]) send_msg(lens[i]);
    while (exp_blk_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 extra block after last message: out_valid=%0d expected 0", out_valid);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule